// File: doc/BRIEF.md
# PLL Lock Event Interrupt Controller

This block watches the lock indicators of three PLLs: main, peripheral and memory. It records each acquisition of lock and each loss of lock as a sticky event bit. A six-bit status vector holds these events. The lower three bits are "lock achieved" events and the upper three are "lock lost" events, in PLL order main, peripheral, memory. Each event bit has its own enable bit. A single interrupt line is raised while any enabled event is pending.

The raw lock inputs arrive from the analog PLLs and are asynchronous to the block clock. Each one passes through a two-flop synchroniser before edge detection. The synchronised levels are also presented directly, so software can read the present lock state apart from the sticky history.

Software reaches the block through a one-cycle write port. The port carries an operation code and an eight-bit mask. The operations are: clear status bits, set enable bits, clear enable bits, and no operation. Status and enable are presented continuously as outputs, so they can be read back at any time.

Top module: `pll_lock_irq`

## Requirements
- R1: `lock_level[i]` shows `lock_raw[i]` after two rising clock edges (two-flop synchroniser). Bit 0 is main, bit 1 is peripheral, bit 2 is memory.
- R2: A 0-to-1 transition of the synchronised lock of PLL i sets `status[i]` (bits 0..2) on the edge after the level changes, three edges after `lock_raw`.
- R3: A 1-to-0 transition of the synchronised lock of PLL i sets `status[i+3]` (bits 3..5) with the same latency as R2.
- R4: A status bit, once set, stays set until a clear-status operation names it in its mask.
- R5: A write with `wr_op` = 2'b00 clears exactly the status bits whose mask bits are 1. Status bits with mask bit 0 are unchanged.
- R6: A write with `wr_op` = 2'b01 sets exactly the enable bits whose mask bits are 1. The other enable bits are unchanged.
- R7: A write with `wr_op` = 2'b10 clears exactly the enable bits whose mask bits are 1. A write with `wr_op` = 2'b11 changes nothing.
- R8: `irq` is high exactly when some bit position is 1 in both `status` and `enable`.
- R9: If an event arrives on the same edge as a clear-status write that names its bit, the bit ends up set.
- R10: Mask bits 7..6 have no effect on status or enable. `mask_err` is high for the one cycle after any write whose mask has bit 7 or bit 6 set.
- R11: After reset, status, enable, `irq` and `mask_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| lock_raw | input | 3 | Unsynchronised PLL lock indicators (main, peripheral, memory) |
| wr_en | input | 1 | One-cycle write strobe |
| wr_op | input | 2 | Operation: 00 clear status, 01 set enable, 10 clear enable, 11 none |
| wr_mask | input | 8 | Bit mask for the operation; only bits 5..0 are valid |
| status | output | 6 | Sticky events: [2:0] lock achieved, [5:3] lock lost |
| enable | output | 6 | Per-event interrupt enables |
| lock_level | output | 3 | Synchronised present lock level |
| irq | output | 1 | OR of enabled pending events |
| mask_err | output | 1 | Pulse flagging a write that used mask bits above 5 |

## Verification
The bench checks that a clear-status write landing on the same edge as a loss-of-lock event leaves the event bit set. A design that gave the clear priority would drop that event and read zero. It drives two PLLs through a rising and a falling edge together, to show that each event is kept apart from the others. A design that shared edge logic, or mixed up bit positions, would set the wrong bits. It also sends masks with only the upper bits set. A design that let those bits leak through would alter enable, and a design that did not flag them would leave `mask_err` low. Finally, it toggles enables while events are pending, to show that `irq` follows only the enabled subset.

// File: rtl/pll_lock_irq.sv
module pll_lock_irq #(
  parameter int N_PLL  = 3,
  parameter int MASK_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_PLL-1:0]     lock_raw,
  input  logic                 wr_en,
  input  logic [1:0]           wr_op,
  input  logic [MASK_W-1:0]    wr_mask,
  output logic [2*N_PLL-1:0]   status,
  output logic [2*N_PLL-1:0]   enable,
  output logic [N_PLL-1:0]     lock_level,
  output logic                 irq,
  output logic                 mask_err
);
  localparam int EV_W = 2 * N_PLL;

  logic [N_PLL-1:0] sync_q [SYNC_N];
  logic [N_PLL-1:0] prev_q;
  logic [EV_W-1:0]  evt;
  logic [EV_W-1:0]  msk;
  logic             do_clr, do_set, do_dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_N; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= lock_raw;
      for (int s = 1; s < SYNC_N; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign lock_level = sync_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lock_level;
  end

  genvar g;
  generate
    for (g = 0; g < N_PLL; g++) begin : g_edge
      assign evt[g]         =  lock_level[g] & ~prev_q[g];
      assign evt[g + N_PLL] = ~lock_level[g] &  prev_q[g];
    end
  endgenerate

  assign msk    = wr_mask[EV_W-1:0];
  assign do_clr = wr_en && (wr_op == 2'b00);
  assign do_set = wr_en && (wr_op == 2'b01);
  assign do_dis = wr_en && (wr_op == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= '0;
      enable   <= '0;
      mask_err <= 1'b0;
    end else begin
      status   <= (status & ~(do_clr ? msk : '0)) | evt;
      if (do_set)      enable <= enable | msk;
      else if (do_dis) enable <= enable & ~msk;
      mask_err <= wr_en && (|wr_mask[MASK_W-1:EV_W]);
    end
  end

  assign irq = |(status & enable);
endmodule

// File: rtl/pll_lock_irq_chk.sv
module pll_lock_irq_chk #(
  parameter int N_PLL  = 3,
  parameter int MASK_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [1:0]           wr_op,
  input logic [MASK_W-1:0]    wr_mask,
  input logic [2*N_PLL-1:0]   status,
  input logic [2*N_PLL-1:0]   enable,
  input logic [N_PLL-1:0]     lock_level,
  input logic                 irq,
  input logic                 mask_err
);
  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && wr_op == 2'b00) |-> ((status & $past(status)) == $past(status)));

  // R6
  enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(enable));

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_err |-> $past(wr_en));

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0 && enable != '0));

  genvar g;
  generate
    for (g = 0; g < N_PLL; g++) begin : g_ev
      // R2
      rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[g]) |-> $past(lock_level[g]));
      // R3
      fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[g+N_PLL]) |-> !$past(lock_level[g]));
    end
  endgenerate
endmodule

bind pll_lock_irq pll_lock_irq_chk #(.N_PLL(N_PLL), .MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_mask(wr_mask),
  .status(status), .enable(enable), .lock_level(lock_level), .irq(irq),
  .mask_err(mask_err)
);

// File: tb/test_pll_lock_irq.sv
module test_pll_lock_irq;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] lock_raw = '0;
  logic       wr_en = 0;
  logic [1:0] wr_op = 2'b11;
  logic [7:0] wr_mask = '0;
  logic [5:0] status, enable;
  logic [2:0] lock_level;
  logic       irq, mask_err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pll_lock_irq i_pll_lock_irq (
    .clk(clk), .rst_n(rst_n), .lock_raw(lock_raw), .wr_en(wr_en),
    .wr_op(wr_op), .wr_mask(wr_mask), .status(status), .enable(enable),
    .lock_level(lock_level), .irq(irq), .mask_err(mask_err)
  );

  // {wr_en, op, mask, lock, status, enable, irq}
  localparam logic [26:0] VEC [0:8] = '{
    {1'b0, 2'd3, 8'h00, 3'b001, 6'h01, 6'h00, 1'b0},  // R2
    {1'b1, 2'd1, 8'h01, 3'b001, 6'h01, 6'h01, 1'b1},  // R6 R8
    {1'b1, 2'd1, 8'h08, 3'b000, 6'h09, 6'h09, 1'b1},  // R3
    {1'b1, 2'd0, 8'h01, 3'b000, 6'h08, 6'h09, 1'b1},  // R5
    {1'b1, 2'd2, 8'h08, 3'b000, 6'h08, 6'h01, 1'b0},  // R7
    {1'b0, 2'd3, 8'h00, 3'b110, 6'h0E, 6'h01, 1'b0},  // R2 R4
    {1'b1, 2'd1, 8'h04, 3'b110, 6'h0E, 6'h05, 1'b1},  // R8
    {1'b1, 2'd3, 8'h3F, 3'b000, 6'h3E, 6'h05, 1'b1},  // R3 R7
    {1'b1, 2'd0, 8'hFF, 3'b000, 6'h00, 6'h05, 1'b0}   // R5
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [1:0] op, input logic [7:0] m, input logic [2:0] l);
    @(negedge clk);
    lock_raw = l; wr_en = w; wr_op = op; wr_mask = m;
    @(negedge clk);
    wr_en = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(status == 0 && enable == 0 && !irq && !mask_err, "R11", {status, enable}, 0);
    rst_n = 1;
    for (int k = 0; k < 9; k++) begin
      step(VEC[k][26], VEC[k][25:24], VEC[k][23:16], VEC[k][15:13]);
      check(status == VEC[k][12:7], "R2/R3/R4/R5 status", status, VEC[k][12:7]);
      check(enable == VEC[k][6:1], "R6/R7 enable", enable, VEC[k][6:1]);
      check(irq == VEC[k][0], "R8 irq", irq, VEC[k][0]);
    end
    // R10 upper mask bits ignored and flagged
    @(negedge clk);
    wr_en = 1; wr_op = 2'b01; wr_mask = 8'h40;
    @(negedge clk);
    wr_en = 0;
    check(mask_err == 1'b1, "R10 err pulse", mask_err, 1);
    check(enable == 6'h05, "R10 enable untouched", enable, 6'h05);
    @(negedge clk);
    check(mask_err == 1'b0, "R10 err one cycle", mask_err, 0);
    // R7 op 11 has no effect
    step(1'b1, 2'd3, 8'h3F, 3'b000);
    check(enable == 6'h05 && status == 0, "R7 nop", {status, enable}, 6'h05);
    // R1 synchroniser latency
    @(negedge clk);
    lock_raw = 3'b101;
    @(negedge clk);
    check(lock_level == 3'b000, "R1 one edge", lock_level, 0);
    @(negedge clk);
    check(lock_level == 3'b101, "R1 two edges", lock_level, 5);
    repeat (2) @(negedge clk);
    check(status == 6'h05, "R2 two PLLs", status, 6'h05);
    step(1'b1, 2'd0, 8'h3F, 3'b101);
    check(status == 0, "R5 clear all", status, 0);
    // R9 event coincides with clear
    @(negedge clk);
    lock_raw = 3'b000;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1; wr_op = 2'b00; wr_mask = 8'h3F;
    @(negedge clk);
    wr_en = 0;
    check(status == 6'h28, "R9 event wins", status, 6'h28);
    check(irq == 1'b0, "R8 disabled events", irq, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule